// File: doc/BRIEF.md
# Reconfiguration Prefetch Arbiter

This controller governs the partial reconfiguration of a region that hosts several hardware modules, each placed at a fixed spot chosen at design time. At every decision point in the program, software hands it a ranked list of candidate module IDs. From that list the controller decides whether to begin a bitstream load, let the current one carry on, or interrupt it in favour of a better-ranked module. Loads are non-blocking. An interrupted load keeps the cycles it has already completed, so a later request for the same module picks up where it stopped. Modules whose placements overlap are in conflict: when a load finishes, every conflicting module loses its resident status.

When execution reaches a candidate module, the controller chooses how to run it:
- If the module is resident, it runs in hardware.
- If the module is still loading and waiting pays off, the controller stalls until the load completes and then runs it in hardware.
- In every other case it sends the work to the software version.

The bitstream transfer is modelled as a countdown, one programmable length per module. The status output always names the module being loaded, or shows all ones when the controller is idle.

Top module: `reconfig_prefetch_ctrl`

## Requirements
- R1: After reset, `cur_id` is all ones (7), `resident` is 0, and `hw_exec`, `sw_exec` and `waiting` are low.
- R2: A load of module m started at a clock edge shows m on `cur_id` from that edge. After the number of cycles still owed for m (its length register, written through `cfg_we`/`cfg_id`/`cfg_len`, minus its kept progress), `resident[m]` rises and `cur_id` returns to 7.
- R3: When list entry 0 (the top rank, bits [2:0] of `q_ids`) is neither resident nor loading, its load is issued on that strobe. This applies even if another load is in progress.
- R4: When entry 0 is resident, the best-ranked non-resident entry is loaded only if the controller is idle. A busy controller whose loading module is absent from the list keeps loading.
- R5: An ongoing load is preempted when the list holds the loading module and also ranks a non-resident module above it. The better-ranked module then starts on the same edge.
- R6: A resumed load needs only the cycles the module still owes, not its full length.
- R7: Completing a load clears `resident` for every module that conflicts with the loaded one. By default, modules 0 and 1 conflict.
- R8: Invoking a resident module gives a one-cycle `hw_exec` pulse on the next cycle, with `wait_cnt` equal to 0.
- R9: Invoking the module that is loading, with R cycles still owed, behaves as follows. If R + `inv_hw` < `inv_sw`, `waiting` rises, `hw_exec` pulses R cycles after the resident case, and `wait_cnt` reads R. Otherwise `sw_exec` pulses on the next cycle.
- R10: Invoking a module that is neither resident nor loading gives a `sw_exec` pulse on the next cycle. `hw_exec` and `sw_exec` are never high together.
- R11: List entries at or beyond `q_cnt`, and entries holding an ID of 4 or more, are ignored. Slot i of `q_ids` is bits [3i+2:3i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for a load-length register |
| cfg_id | input | 3 | Module whose length is written |
| cfg_len | input | 8 | Load duration in cycles |
| q_valid | input | 1 | Ranked list strobe |
| q_cnt | input | 3 | Number of valid list entries |
| q_ids | input | 12 | Four ranked IDs, slot 0 highest |
| inv_valid | input | 1 | Module invocation strobe |
| inv_id | input | 3 | Invoked module |
| inv_hw | input | 8 | Hardware run time of the invoked module |
| inv_sw | input | 8 | Software run time of the invoked module |
| cur_id | output | 3 | Module being loaded, 7 when idle |
| resident | output | 4 | One bit per fully loaded module |
| hw_exec | output | 1 | Pulse: run in hardware |
| sw_exec | output | 1 | Pulse: run in software |
| waiting | output | 1 | Stalled on a load to finish |
| wait_cnt | output | 8 | Cycles stalled by the last invocation |

## Verification
A progress counter that is wrong, or that was cleared on preemption, shows up as a `resident` bit rising early or late after a resumed load, and as a wrong `wait_cnt` on the next invocation of that module. A stale or wrong conflict eviction appears at the next load completion as an incorrect `resident` vector, and turns an expected `hw_exec` into `sw_exec`. Errors in ranking are visible on `cur_id` one cycle after the list strobe.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
   typedef enum logic {
      EX_IDLE = 1'b0,
      EX_WAIT = 1'b1
   } ex_state_t;
endpackage

// File: rtl/rpc_queue_pick.sv
module rpc_queue_pick #(
   parameter int N_MOD  = 4,
   parameter int QDEPTH = 4,
   parameter int ID_W   = 3,
   parameter int IDX_W  = 2,
   parameter int CQ_W   = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    q_valid,
   input  logic [CQ_W-1:0]         q_cnt,
   input  logic [QDEPTH*ID_W-1:0]  q_ids,
   input  logic [N_MOD-1:0]        resident,
   input  logic [ID_W-1:0]         cur_id,
   output logic                    start,
   output logic [ID_W-1:0]         start_id
);
   localparam logic [ID_W-1:0] NONE_ID = '1;
   localparam logic [ID_W-1:0] NMOD_ID = ID_W'(N_MOD);

   logic            found, on_list, idle;
   logic [CQ_W-1:0] tgt_rank;
   logic [ID_W-1:0] ent;

   assign idle = (cur_id == NONE_ID);

   always_comb begin
      found    = 1'b0;
      on_list  = 1'b0;
      tgt_rank = '0;
      start_id = NONE_ID;
      ent      = '0;
      for (int i = 0; i < QDEPTH; i++) begin
         ent = q_ids[i*ID_W +: ID_W];
         if ((CQ_W'(i) < q_cnt) && (ent < NMOD_ID)) begin
            if (!found && !resident[ent[IDX_W-1:0]]) begin
               found    = 1'b1;
               tgt_rank = CQ_W'(i);
               start_id = ent;
            end
            if (ent == cur_id) on_list = 1'b1;
         end
      end
      start = q_valid && found && (start_id != cur_id) &&
              (idle || (tgt_rank == '0) || on_list);
   end

   logic [ID_W-1:0] head;
   logic            head_ok;
   assign head    = q_ids[ID_W-1:0];
   assign head_ok = (q_cnt != '0) && (head < NMOD_ID);

   AST_PICK_IS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (start_id < NMOD_ID) && !resident[start_id[IDX_W-1:0]]) else $error("pick"); // R11
   AST_HEAD_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && head_ok && !resident[head[IDX_W-1:0]] && head != cur_id)
      |-> (start && start_id == head)) else $error("head"); // R3
endmodule

// File: rtl/rpc_load_engine.sv
module rpc_load_engine #(
   parameter int                       N_MOD       = 4,
   parameter int                       ID_W        = 3,
   parameter int                       IDX_W       = 2,
   parameter int                       CNT_W       = 8,
   parameter int                       RST_LEN     = 1,
   parameter logic [N_MOD*N_MOD-1:0]   CONFLICT_MAP = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ID_W-1:0]   cfg_id,
   input  logic [CNT_W-1:0]  cfg_len,
   input  logic              start,
   input  logic [ID_W-1:0]   start_id,
   input  logic [ID_W-1:0]   qry_id,
   output logic [ID_W-1:0]   cur_id,
   output logic [N_MOD-1:0]  resident,
   output logic [CNT_W-1:0]  qry_rem
);
   localparam logic [ID_W-1:0] NONE_ID = '1;

   logic [CNT_W-1:0] len_q  [N_MOD];
   logic [CNT_W-1:0] prog_q [N_MOD];
   logic             loading, done;
   logic [IDX_W-1:0] cur_idx, qry_idx;

   assign loading = (cur_id != NONE_ID);
   assign cur_idx = cur_id[IDX_W-1:0];
   assign qry_idx = qry_id[IDX_W-1:0];
   assign done    = loading &&
                    (({1'b0, prog_q[cur_idx]} + 1'b1) >= {1'b0, len_q[cur_idx]});
   assign qry_rem = len_q[qry_idx] - prog_q[qry_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_id   <= NONE_ID;
         resident <= '0;
         for (int m = 0; m < N_MOD; m++) begin
            len_q[m]  <= CNT_W'(RST_LEN);
            prog_q[m] <= '0;
         end
      end else begin
         for (int m = 0; m < N_MOD; m++) begin
            if (cfg_we && cfg_id == ID_W'(m)) len_q[m] <= cfg_len;
            if (loading && cur_idx == IDX_W'(m))
               prog_q[m] <= done ? '0 : prog_q[m] + 1'b1;
            if (done) begin
               if (cur_idx == IDX_W'(m))
                  resident[m] <= 1'b1;
               else if (CONFLICT_MAP[int'(cur_idx)*N_MOD + m])
                  resident[m] <= 1'b0;
            end
         end
         if (start)     cur_id <= start_id;
         else if (done) cur_id <= NONE_ID;
      end
   end

   AST_CUR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_id == NONE_ID) || (cur_id < ID_W'(N_MOD))) else $error("cur"); // R2
   AST_LOAD_ENDS_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> resident[$past(cur_idx)]) else $error("done"); // R2
   AST_LOADING_NOT_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
      loading |-> !resident[cur_idx]) else $error("loadres"); // R3

   for (genvar i = 0; i < N_MOD; i++) begin : g_ci
      for (genvar j = i + 1; j < N_MOD; j++) begin : g_cj
         if (CONFLICT_MAP[i*N_MOD + j]) begin : g_pair
            AST_NO_CONFLICT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
               !(resident[i] && resident[j])) else $error("conflict"); // R7
         end
      end
   end
endmodule

// File: rtl/rpc_exec_decide.sv
module rpc_exec_decide
   import rpc_pkg::*;
#(
   parameter int N_MOD = 4,
   parameter int ID_W  = 3,
   parameter int IDX_W = 2,
   parameter int CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inv_valid,
   input  logic [ID_W-1:0]   inv_id,
   input  logic [CNT_W-1:0]  inv_hw,
   input  logic [CNT_W-1:0]  inv_sw,
   input  logic [N_MOD-1:0]  resident,
   input  logic [ID_W-1:0]   cur_id,
   input  logic [CNT_W-1:0]  qry_rem,
   output logic              hw_exec,
   output logic              sw_exec,
   output logic              waiting,
   output logic [CNT_W-1:0]  wait_cnt
);
   ex_state_t        st;
   logic [ID_W-1:0]  w_id;
   logic             inv_ok, pays_off;
   logic [IDX_W-1:0] inv_idx;

   assign inv_idx  = inv_id[IDX_W-1:0];
   assign inv_ok   = (inv_id < ID_W'(N_MOD));
   assign pays_off = ({1'b0, qry_rem} + {1'b0, inv_hw}) < {1'b0, inv_sw};
   assign waiting  = (st == EX_WAIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= EX_IDLE;
         w_id     <= '0;
         hw_exec  <= 1'b0;
         sw_exec  <= 1'b0;
         wait_cnt <= '0;
      end else begin
         hw_exec <= 1'b0;
         sw_exec <= 1'b0;
         case (st)
            EX_IDLE: if (inv_valid) begin
               wait_cnt <= '0;
               if (inv_ok && resident[inv_idx]) begin
                  hw_exec <= 1'b1;
               end else if (inv_ok && cur_id == inv_id && pays_off) begin
                  st   <= EX_WAIT;
                  w_id <= inv_id;
               end else begin
                  sw_exec <= 1'b1;
               end
            end
            EX_WAIT: begin
               wait_cnt <= wait_cnt + 1'b1;
               if (resident[w_id[IDX_W-1:0]]) begin
                  hw_exec <= 1'b1;
                  st      <= EX_IDLE;
               end else if (cur_id != w_id) begin
                  sw_exec <= 1'b1;
                  st      <= EX_IDLE;
               end
            end
            default: st <= EX_IDLE;
         endcase
      end
   end

   AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(hw_exec && sw_exec)) else $error("both"); // R10
   AST_RESIDENT_RUNS_HW: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !waiting && inv_ok && resident[inv_idx]) |=> hw_exec) else $error("res"); // R8
   AST_WAIT_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && resident[w_id[IDX_W-1:0]]) |=> (hw_exec && !waiting)) else $error("wait"); // R9
   AST_BAD_ID_SW: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !waiting && !inv_ok) |=> sw_exec) else $error("badid"); // R10
endmodule

// File: rtl/reconfig_prefetch_ctrl.sv
module reconfig_prefetch_ctrl #(
   parameter int                     N_MOD        = 4,
   parameter int                     QDEPTH       = 4,
   parameter int                     CNT_W        = 8,
   parameter int                     RST_LEN      = 1,
   parameter logic [N_MOD*N_MOD-1:0] CONFLICT_MAP = 16'h0012,
   localparam int                    ID_W         = $clog2(N_MOD + 1),
   localparam int                    IDX_W        = (N_MOD > 1) ? $clog2(N_MOD) : 1,
   localparam int                    CQ_W         = $clog2(QDEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [ID_W-1:0]         cfg_id,
   input  logic [CNT_W-1:0]        cfg_len,
   input  logic                    q_valid,
   input  logic [CQ_W-1:0]         q_cnt,
   input  logic [QDEPTH*ID_W-1:0]  q_ids,
   input  logic                    inv_valid,
   input  logic [ID_W-1:0]         inv_id,
   input  logic [CNT_W-1:0]        inv_hw,
   input  logic [CNT_W-1:0]        inv_sw,
   output logic [ID_W-1:0]         cur_id,
   output logic [N_MOD-1:0]        resident,
   output logic                    hw_exec,
   output logic                    sw_exec,
   output logic                    waiting,
   output logic [CNT_W-1:0]        wait_cnt
);
   if (N_MOD < 2)   begin : g_bad_nmod  $error("N_MOD must be at least 2");  end
   if (QDEPTH < 1)  begin : g_bad_depth $error("QDEPTH must be at least 1"); end
   if (CNT_W < 2)   begin : g_bad_cnt   $error("CNT_W must be at least 2");  end
   for (genvar i = 0; i < N_MOD; i++) begin : g_mi
      if (CONFLICT_MAP[i*N_MOD + i]) begin : g_diag $error("module conflicts with itself"); end
      for (genvar j = 0; j < N_MOD; j++) begin : g_mj
         if (CONFLICT_MAP[i*N_MOD + j] != CONFLICT_MAP[j*N_MOD + i]) begin : g_asym
            $error("conflict map not symmetric");
         end
      end
   end

   logic            start;
   logic [ID_W-1:0] start_id;
   logic [CNT_W-1:0] qry_rem;

   rpc_queue_pick #(
      .N_MOD(N_MOD), .QDEPTH(QDEPTH), .ID_W(ID_W), .IDX_W(IDX_W), .CQ_W(CQ_W)
   ) u_pick (
      .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_cnt(q_cnt), .q_ids(q_ids),
      .resident(resident), .cur_id(cur_id), .start(start), .start_id(start_id)
   );

   rpc_load_engine #(
      .N_MOD(N_MOD), .ID_W(ID_W), .IDX_W(IDX_W), .CNT_W(CNT_W),
      .RST_LEN(RST_LEN), .CONFLICT_MAP(CONFLICT_MAP)
   ) u_load (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_len(cfg_len),
      .start(start), .start_id(start_id), .qry_id(inv_id),
      .cur_id(cur_id), .resident(resident), .qry_rem(qry_rem)
   );

   rpc_exec_decide #(
      .N_MOD(N_MOD), .ID_W(ID_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_exec (
      .clk(clk), .rst_n(rst_n), .inv_valid(inv_valid), .inv_id(inv_id),
      .inv_hw(inv_hw), .inv_sw(inv_sw), .resident(resident), .cur_id(cur_id),
      .qry_rem(qry_rem), .hw_exec(hw_exec), .sw_exec(sw_exec),
      .waiting(waiting), .wait_cnt(wait_cnt)
   );
endmodule

// File: tb/reconfig_prefetch_ctrl_tb.sv
module reconfig_prefetch_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_id = '0;
   logic [7:0]  cfg_len = '0;
   logic        q_valid = 1'b0;
   logic [2:0]  q_cnt = '0;
   logic [11:0] q_ids = '0;
   logic        inv_valid = 1'b0;
   logic [2:0]  inv_id = '0;
   logic [7:0]  inv_hw = '0;
   logic [7:0]  inv_sw = '0;
   logic [2:0]  cur_id;
   logic [3:0]  resident;
   logic        hw_exec, sw_exec, waiting;
   logic [7:0]  wait_cnt;

   int n_chk = 0;
   int n_err = 0;
   bit done_flag = 1'b0;

   always #10 clk = ~clk;

   reconfig_prefetch_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_len(cfg_len),
      .q_valid(q_valid), .q_cnt(q_cnt), .q_ids(q_ids), .inv_valid(inv_valid),
      .inv_id(inv_id), .inv_hw(inv_hw), .inv_sw(inv_sw), .cur_id(cur_id),
      .resident(resident), .hw_exec(hw_exec), .sw_exec(sw_exec),
      .waiting(waiting), .wait_cnt(wait_cnt)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [11:0] ids4(int a, int b, int c, int d);
      return {3'(d), 3'(c), 3'(b), 3'(a)};
   endfunction

   task automatic push_list(int cnt, logic [11:0] ids);
      q_valid = 1'b1; q_cnt = 3'(cnt); q_ids = ids;
      tick(1);
      q_valid = 1'b0;
   endtask

   task automatic invoke(int id, int hw, int sw);
      inv_valid = 1'b1; inv_id = 3'(id); inv_hw = 8'(hw); inv_sw = 8'(sw);
      tick(1);
      inv_valid = 1'b0;
   endtask

   task automatic set_len(int id, int len);
      cfg_we = 1'b1; cfg_id = 3'(id); cfg_len = 8'(len);
      tick(1);
      cfg_we = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 cur_id", int'(cur_id), 7);
      chk("R1 resident", int'(resident), 0);
      chk("R1 pulses", int'({hw_exec, sw_exec, waiting}), 0);
   endtask

   task automatic t_fresh_load;
      push_list(1, ids4(2, 0, 0, 0));
      chk("R3 head issued", int'(cur_id), 2);
      tick(19);
      chk("R2 still loading", int'(resident[2]), 0);
      tick(1);
      chk("R2 resident after length", int'(resident), 4'b0100);
      chk("R2 idle code", int'(cur_id), 7);
      push_list(2, ids4(2, 3, 0, 0));
      chk("R4 next rank when idle", int'(cur_id), 3);
      tick(4);
      chk("R4 next loaded", int'(resident), 4'b1100);
   endtask

   task automatic t_preempt;
      push_list(1, ids4(0, 0, 0, 0));
      tick(3);
      push_list(2, ids4(2, 1, 0, 0));
      chk("R4 busy not preempted", int'(cur_id), 0);
      push_list(3, ids4(2, 1, 0, 0));
      chk("R5 preempted by better rank", int'(cur_id), 1);
      tick(5);
      chk("R2 m1 not yet", int'(resident[1]), 0);
      tick(1);
      chk("R2 m1 resident", int'(resident), 4'b1110);
   endtask

   task automatic t_resume;
      push_list(1, ids4(0, 0, 0, 0));
      chk("R3 resume issued", int'(cur_id), 0);
      tick(4);
      chk("R6 not yet resumed-complete", int'(resident[0]), 0);
      tick(1);
      chk("R6 R7 resumed complete evicts m1", int'(resident), 4'b1101);
   endtask

   task automatic t_invoke_simple;
      invoke(2, 3, 10);
      chk("R8 hw pulse", int'({hw_exec, sw_exec}), 2);
      chk("R8 no wait", int'(wait_cnt), 0);
      tick(1);
      chk("R8 pulse one cycle", int'(hw_exec), 0);
      invoke(1, 3, 10);
      chk("R10 sw pulse", int'({hw_exec, sw_exec}), 1);
   endtask

   task automatic t_invoke_wait;
      push_list(1, ids4(1, 0, 0, 0));
      tick(2);
      invoke(1, 1, 10);
      chk("R9 waiting", int'({waiting, hw_exec, sw_exec}), 4);
      tick(2);
      chk("R9 no early hw", int'(hw_exec), 0);
      tick(1);
      chk("R7 m0 evicted by m1", int'(resident), 4'b1110);
      chk("R9 still no hw", int'(hw_exec), 0);
      tick(1);
      chk("R9 hw after wait", int'({waiting, hw_exec}), 1);
      chk("R9 wait count", int'(wait_cnt), 4);
   endtask

   task automatic t_invoke_tradeoff;
      push_list(1, ids4(0, 0, 0, 0));
      tick(1);
      invoke(0, 5, 12);
      chk("R9 too slow to wait", int'({hw_exec, sw_exec}), 1);
      invoke(0, 4, 12);
      chk("R9 equal is software", int'({hw_exec, sw_exec}), 1);
      invoke(0, 4, 12);
      chk("R9 one under waits", int'(waiting), 1);
      tick(6);
      chk("R9 hw not before 7", int'(hw_exec), 0);
      tick(1);
      chk("R9 hw at 7", int'(hw_exec), 1);
      chk("R9 wait count 7", int'(wait_cnt), 7);
      chk("R7 m1 evicted by m0", int'(resident), 4'b1101);
   endtask

   task automatic t_ignored;
      push_list(2, ids4(3, 5, 1, 0));
      chk("R11 invalid and beyond-count ignored", int'(cur_id), 7);
      push_list(1, ids4(6, 1, 0, 0));
      chk("R11 invalid head ignored", int'(cur_id), 7);
      push_list(3, ids4(3, 6, 1, 0));
      chk("R11 invalid skipped", int'(cur_id), 1);
      push_list(2, ids4(3, 2, 0, 0));
      chk("R4 all resident keeps load", int'(cur_id), 1);
   endtask

   initial begin
      tick(2);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      set_len(0, 10);
      set_len(1, 6);
      set_len(2, 20);
      set_len(3, 4);
      t_fresh_load();
      t_preempt();
      t_resume();
      t_invoke_simple();
      t_invoke_wait();
      t_invoke_tradeoff();
      t_ignored();
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule